// File: doc/BRIEF.md
# Core-to-Host Transmit Channel

This block carries 24-bit words from a processor core out to an external host over a parallel byte-wide bus. The core writes a word into a transmit holding register. The block then moves that word into a host-visible receive register as soon as the host has emptied the previous one. The host reads the word back one byte at a time. A flag on each side follows the handshake. The core sees a transmit-empty flag, and can use it to raise an interrupt request. The host sees a receive-full flag, which it can read directly or as a status byte.

Two state machines do the work. The core-side machine has two states. `TX_EMPTY` means no word is pending. `TX_HELD` means a word is waiting for the host register. Its transitions are *load* (`TX_EMPTY` to `TX_HELD` on a core write) and *move* (`TX_HELD` to `TX_EMPTY` when receive-full is clear, which copies the word across). The host-side machine has three states. `H_IDLE` waits for a strobe. `H_READ` and `H_WRITE` track an access in progress. Its transitions are *open-read* and *open-write* (`H_IDLE` to the access state once the synchronized strobe is seen active) and *close* (back to `H_IDLE` when the synchronized strobe goes inactive). An access takes effect only at *close*.

A mode input selects the host strobe style. Single-strobe mode uses a data strobe plus a read/write line. Dual-strobe mode uses separate read and write strobes. All strobes are active low. Host writes are accepted on the bus but have no effect, because this channel only carries data toward the host.

Top module: `hxc_top`

## Requirements
- R1: After reset, `core_empty` is 1, `host_rxfull` is 0, `core_irq` is 0, `core_overrun` is 0, and all three receive bytes read as 0x00.
- R2: A core write while no word is pending loads the word and clears the internal empty state at the next clock edge. `core_empty` shows the new value two clock edges after the write edge. On the edge right after the write, it still shows the old value.
- R3: A pending word is not moved while `host_rxfull` is 1, and the receive bytes stay unchanged during that time.
- R4: When a word is pending and `host_rxfull` is 0, the word is copied into the receive register at the next edge, `host_rxfull` becomes 1, and the core side returns to empty. Byte address 0 returns bits 23:16, address 1 returns bits 15:8, and address 2 returns bits 7:0.
- R5: `core_irq` is 1 exactly when the interrupt enable (written through `core_ctl_we`/`core_ctl_ie`) is 1 and `core_empty` is 1.
- R6: A core write while a word is pending raises `core_overrun` for one cycle after that edge. The write is discarded and the pending word is delivered unchanged.
- R7: With `host_dual_mode`=0, an access is qualified by `host_ds_n` low. `host_rw`=1 marks it as a read and `host_rw`=0 as a write.
- R8: With `host_dual_mode`=1, `host_rd_n` low qualifies a read and `host_wr_n` low qualifies a write.
- R9: A completed host read of address 2 clears `host_rxfull`. A read completes once the synchronized strobe deasserts. Reads of addresses 0, 1 and 3 leave the flag unchanged.
- R10: Host write accesses to any address change neither `host_rxfull` nor the receive bytes.
- R11: Address 3 returns a status byte with `host_rxfull` in bit 0 and zeros in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_wr_en | input | 1 | Core write strobe for the transmit register |
| core_wr_data | input | 24 | Word written by the core |
| core_ctl_we | input | 1 | Write strobe for the interrupt enable bit |
| core_ctl_ie | input | 1 | Interrupt enable value written with `core_ctl_we` |
| core_empty | output | 1 | Transmit-empty flag as seen by the core (two-cycle lag) |
| core_irq | output | 1 | Transmit interrupt request |
| core_overrun | output | 1 | One-cycle pulse: a write was refused while a word was pending |
| host_dual_mode | input | 1 | 0: single strobe plus read/write line; 1: separate read and write strobes |
| host_ds_n | input | 1 | Data strobe, single-strobe mode, active low |
| host_rw | input | 1 | Direction in single-strobe mode, 1 = read |
| host_rd_n | input | 1 | Read strobe, dual-strobe mode, active low |
| host_wr_n | input | 1 | Write strobe, dual-strobe mode, active low |
| host_addr | input | 2 | Byte select: 0 high, 1 middle, 2 low, 3 status |
| host_rdata | output | 8 | Selected byte, combinational from `host_addr` |
| host_rxfull | output | 1 | Receive-full flag |

## Verification
A core write is taken at edge k. `core_overrun` is therefore checked half a cycle after k. `core_empty` is checked after k+1, where it must still show the old value, after k+2, where it shows the new value, and after k+3, where the move has already restored it. `host_rxfull` is due one edge after a move. A host access takes effect only after two synchronizer stages and the *close* transition. The bench therefore holds each strobe active for four cycles and idle for six, and samples the flag only after that wait. All samples and stimulus changes are made on the falling clock edge. Each pattern of the data sweep is run through both strobe modes.

// File: rtl/hxc_pkg.sv
package hxc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        TX_EMPTY = 1'b0,
        TX_HELD  = 1'b1
    } tx_state_t;

    typedef enum logic [1:0] {
        H_IDLE  = 2'd0,
        H_READ  = 2'd1,
        H_WRITE = 2'd2
    } hst_state_t;

endpackage

// File: rtl/hxc_sync.sv
module hxc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hxc_core_side.sv
module hxc_core_side
    import hxc_pkg::*;
#(
    parameter int DATA_W     = 24,
    parameter int STATUS_LAG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ctl_we,
    input  logic              ctl_ie,
    input  logic              rx_full,
    output logic [DATA_W-1:0] tx_word,
    output logic              xfer,
    output logic              empty_now,
    output logic              empty_seen,
    output logic              irq,
    output logic              overrun,
    output logic              ie
);
    tx_state_t state_q, state_d;
    logic      accept;
    logic      refuse;
    logic [STATUS_LAG-1:0] lag_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        refuse  = 1'b0;
        xfer    = 1'b0;
        unique case (state_q)
            TX_EMPTY: begin
                if (wr_en) begin
                    accept  = 1'b1;
                    state_d = TX_HELD;      // load
                end
            end
            TX_HELD: begin
                if (wr_en) refuse = 1'b1;
                if (!rx_full) begin
                    xfer    = 1'b1;
                    state_d = TX_EMPTY;     // move
                end
            end
            default: state_d = TX_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    // registered outputs and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '0;
            overrun <= 1'b0;
            ie      <= 1'b0;
        end else begin
            if (accept) tx_word <= wr_data;
            overrun <= refuse;
            if (ctl_we) ie <= ctl_ie;
        end
    end

    assign empty_now = (state_q == TX_EMPTY);

    generate
        if (STATUS_LAG == 1) begin : g_lag1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lag_q <= '1;
                else        lag_q <= empty_now;
            end
        end else begin : g_lagn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lag_q <= '1;
                else        lag_q <= {lag_q[STATUS_LAG-2:0], empty_now};
            end
        end
    endgenerate

    assign empty_seen = lag_q[STATUS_LAG-1];
    assign irq        = ie & empty_seen;
endmodule

// File: rtl/hxc_host_side.sv
module hxc_host_side
    import hxc_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dual_mode,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              xfer,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_full,
    output logic [BYTE_W-1:0] rdata,
    output logic              rd_low_done
);
    localparam int NBYTES = DATA_W / BYTE_W;
    localparam logic [ADDR_W-1:0] LOW_ADDR  = ADDR_W'(NBYTES - 1);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NBYTES);

    logic raw_rd, raw_wr;
    logic rd_s, wr_s;
    logic rd_done;
    logic [ADDR_W-1:0] addr_q;
    hst_state_t h_q, h_d;
    logic [BYTE_W-1:0] byte_at [NBYTES];

    // strobe decoding per mode
    always_comb begin
        if (dual_mode) begin
            raw_rd = ~rd_n;
            raw_wr = ~wr_n;
        end else begin
            raw_rd = ~ds_n & rw;
            raw_wr = ~ds_n & ~rw;
        end
    end

    hxc_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (
        .clk(clk), .rst_n(rst_n), .d(raw_rd), .q(rd_s)
    );
    hxc_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
        .clk(clk), .rst_n(rst_n), .d(raw_wr), .q(wr_s)
    );

    // next-state logic
    always_comb begin
        h_d     = h_q;
        rd_done = 1'b0;
        unique case (h_q)
            H_IDLE: begin
                if (rd_s)      h_d = H_READ;   // open-read
                else if (wr_s) h_d = H_WRITE;  // open-write
            end
            H_READ: begin
                if (!rd_s) begin
                    h_d     = H_IDLE;          // close
                    rd_done = 1'b1;
                end
            end
            H_WRITE: begin
                if (!wr_s) h_d = H_IDLE;       // close, data discarded
            end
            default: h_d = H_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= H_IDLE;
        else        h_q <= h_d;
    end

    // access address capture and receive register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rx_word <= '0;
            rx_full <= 1'b0;
        end else begin
            if (h_q == H_IDLE && rd_s) addr_q <= addr;
            if (xfer) begin
                rx_word <= tx_word;
                rx_full <= 1'b1;
            end else if (rd_low_done) begin
                rx_full <= 1'b0;
            end
        end
    end

    assign rd_low_done = rd_done && (addr_q == LOW_ADDR);

    generate
        for (genvar i = 0; i < NBYTES; i++) begin : g_bytes
            assign byte_at[i] = rx_word[DATA_W-1-BYTE_W*i -: BYTE_W];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == ADDR_W'(i)) rdata = byte_at[i];
        end
        if (addr == STAT_ADDR) rdata = {{(BYTE_W-1){1'b0}}, rx_full};
    end
endmodule

// File: rtl/hxc_top.sv
module hxc_top
    import hxc_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int STATUS_LAG  = 2,
    parameter int ADDR_W      = $clog2(DATA_W / 8 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_wr_en,
    input  logic [DATA_W-1:0] core_wr_data,
    input  logic              core_ctl_we,
    input  logic              core_ctl_ie,
    output logic              core_empty,
    output logic              core_irq,
    output logic              core_overrun,
    input  logic              host_dual_mode,
    input  logic              host_ds_n,
    input  logic              host_rw,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [7:0]        host_rdata,
    output logic              host_rxfull
);
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] rx_word;
    logic              xfer;
    logic              tx_empty_now;
    logic              ie_q;
    logic              rd_low_done;

    hxc_core_side #(
        .DATA_W(DATA_W), .STATUS_LAG(STATUS_LAG)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_en(core_wr_en), .wr_data(core_wr_data),
        .ctl_we(core_ctl_we), .ctl_ie(core_ctl_ie),
        .rx_full(host_rxfull),
        .tx_word(tx_word), .xfer(xfer),
        .empty_now(tx_empty_now), .empty_seen(core_empty),
        .irq(core_irq), .overrun(core_overrun), .ie(ie_q)
    );

    hxc_host_side #(
        .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
    ) u_host (
        .clk(clk), .rst_n(rst_n),
        .dual_mode(host_dual_mode),
        .ds_n(host_ds_n), .rw(host_rw),
        .rd_n(host_rd_n), .wr_n(host_wr_n),
        .addr(host_addr),
        .tx_word(tx_word), .xfer(xfer),
        .rx_word(rx_word), .rx_full(host_rxfull),
        .rdata(host_rdata), .rd_low_done(rd_low_done)
    );
endmodule

// File: rtl/hxc_checker.sv
module hxc_checker #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_wr_en,
    input logic              core_empty,
    input logic              core_irq,
    input logic              core_overrun,
    input logic              host_rxfull,
    input logic              tx_empty_now,
    input logic              ie_q,
    input logic              rd_low_done,
    input logic [DATA_W-1:0] tx_word,
    input logic [DATA_W-1:0] rx_word
);
    a_r2_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && tx_empty_now) |=> !tx_empty_now);

    a_r3_hold_while_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty_now && host_rxfull) |=> $stable(rx_word));

    a_r4_move_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_empty_now && !host_rxfull) |=>
            (host_rxfull && tx_empty_now && rx_word == $past(tx_word)));

    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |-> (ie_q && core_empty));

    a_r6_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wr_en && !tx_empty_now) |=> (core_overrun && $stable(tx_word)));

    a_r9_full_cleared_by_low_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rxfull) |-> $past(rd_low_done));
endmodule

bind hxc_top hxc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .core_wr_en(core_wr_en), .core_empty(core_empty),
    .core_irq(core_irq), .core_overrun(core_overrun),
    .host_rxfull(host_rxfull), .tx_empty_now(tx_empty_now),
    .ie_q(ie_q), .rd_low_done(rd_low_done),
    .tx_word(tx_word), .rx_word(rx_word)
);

// File: tb/hxc_top_tb.sv
module hxc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_wr_en = 1'b0;
    logic [23:0] core_wr_data = '0;
    logic        core_ctl_we = 1'b0;
    logic        core_ctl_ie = 1'b0;
    logic        core_empty, core_irq, core_overrun;
    logic        host_dual_mode = 1'b0;
    logic        host_ds_n = 1'b1;
    logic        host_rw = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_rdata;
    logic        host_rxfull;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hxc_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .core_wr_en(core_wr_en), .core_wr_data(core_wr_data),
        .core_ctl_we(core_ctl_we), .core_ctl_ie(core_ctl_ie),
        .core_empty(core_empty), .core_irq(core_irq), .core_overrun(core_overrun),
        .host_dual_mode(host_dual_mode), .host_ds_n(host_ds_n), .host_rw(host_rw),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_addr(host_addr),
        .host_rdata(host_rdata), .host_rxfull(host_rxfull)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // returns just after the write edge
    task automatic core_write(input logic [23:0] d);
        @(negedge clk);
        core_wr_en = 1'b1;
        core_wr_data = d;
        @(negedge clk);
        core_wr_en = 1'b0;
    endtask

    task automatic set_ie(input logic v);
        @(negedge clk);
        core_ctl_we = 1'b1;
        core_ctl_ie = v;
        @(negedge clk);
        core_ctl_we = 1'b0;
    endtask

    task automatic strobe_on(input bit rd);
        if (host_dual_mode) begin
            if (rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
        end else begin
            host_ds_n = 1'b0;
        end
    endtask

    task automatic strobe_off();
        host_ds_n = 1'b1;
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        host_rw = 1'b1;
        @(negedge clk);
        strobe_on(1'b1);
        repeat (4) @(negedge clk);
        v = host_rdata;
        strobe_off();
        repeat (6) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] a);
        @(negedge clk);
        host_addr = a;
        host_rw = 1'b0;
        @(negedge clk);
        strobe_on(1'b0);
        repeat (4) @(negedge clk);
        strobe_off();
        @(negedge clk);
        host_rw = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        logic [7:0] b;
        logic [23:0] wa, wb, wc;
        string mtag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 empty", core_empty, 1);
        check("R1 full", host_rxfull, 0);
        check("R1 irq", core_irq, 0);
        check("R1 overrun", core_overrun, 0);
        for (int a = 0; a < 3; a++) begin
            host_read(a[1:0], b);
            check("R1 byte", b, 0);
        end
        check("R1 full after reads", host_rxfull, 0);

        // R5 irq gating while empty
        set_ie(1'b1);
        check("R5 irq enabled+empty", core_irq, 1);
        set_ie(1'b0);
        check("R5 irq disabled", core_irq, 0);

        // data sweep across both strobe modes
        for (int m = 0; m < 2; m++) begin
            host_dual_mode = m[0];
            mtag = (m == 0) ? "R7" : "R8";
            for (int p = 0; p < 6; p++) begin
                logic [23:0] d;
                d = (24'(p) * 24'h13579B) ^ ((m == 0) ? 24'h0F1E2D : 24'hA5C3E1);
                core_write(d);
                @(negedge clk);
                check("R2 empty old value", core_empty, 1);
                check("R4 full after move", host_rxfull, 1);
                @(negedge clk);
                check("R2 empty lagged clear", core_empty, 0);
                @(negedge clk);
                check("R4 empty restored", core_empty, 1);
                host_read(2'd0, b);
                check({mtag, " R4 high byte"}, b, d[23:16]);
                host_read(2'd1, b);
                check({mtag, " R4 mid byte"}, b, d[15:8]);
                check("R9 full kept after high/mid", host_rxfull, 1);
                host_read(2'd3, b);
                check("R11 status full", b, 8'h01);
                check("R9 full kept after status", host_rxfull, 1);
                host_read(2'd2, b);
                check({mtag, " R4 low byte"}, b, d[7:0]);
                check({mtag, " R9 full cleared"}, host_rxfull, 0);
                host_read(2'd3, b);
                check("R11 status empty", b, 8'h00);
            end
        end

        // blocking, lag and overrun
        host_dual_mode = 1'b0;
        wa = 24'hC0FFEE; wb = 24'h123456; wc = 24'hDEAD01;
        set_ie(1'b1);
        core_write(wa);
        repeat (3) @(negedge clk);
        check("R4 full set", host_rxfull, 1);
        core_write(wb);
        check("R6 no overrun on first pending", core_overrun, 0);
        @(negedge clk);
        check("R2 empty old while pending", core_empty, 1);
        check("R5 irq old", core_irq, 1);
        @(negedge clk);
        check("R2 empty clear while pending", core_empty, 0);
        check("R5 irq off while pending", core_irq, 0);
        core_write(wc);
        check("R6 overrun pulse", core_overrun, 1);
        @(negedge clk);
        check("R6 overrun one cycle", core_overrun, 0);
        repeat (4) @(negedge clk);
        check("R3 still pending", core_empty, 0);
        host_read(2'd0, b);
        check("R3 high byte held", b, wa[23:16]);
        host_read(2'd1, b);
        check("R3 mid byte held", b, wa[15:8]);

        // R10 host writes ignored, both modes
        for (int m = 0; m < 2; m++) begin
            host_dual_mode = m[0];
            host_write(2'd2);
            host_write(2'd0);
            check("R10 full kept", host_rxfull, 1);
            host_read(2'd1, b);
            check("R10 mid byte kept", b, wa[15:8]);
            check("R3 still pending after writes", core_empty, 0);
        end

        host_dual_mode = 1'b1;
        host_read(2'd2, b);
        check("R3 low byte held", b, wa[7:0]);
        check("R3 next word moved", host_rxfull, 1);
        check("R5 irq back with empty", core_irq, 1);
        host_read(2'd0, b);
        check("R6 pending word high", b, wb[23:16]);
        host_read(2'd1, b);
        check("R6 pending word mid", b, wb[15:8]);
        host_read(2'd2, b);
        check("R6 pending word low", b, wb[7:0]);
        check("R6 refused word not delivered", host_rxfull, 0);

        finish_run();
    end
endmodule